// File: doc/BRIEF.md
# Dual-Channel Prescaled Down-Counting Timer

This peripheral holds two independent 16-bit timer channels. Both run from one shared functional clock, so any change to that clock affects the two channels together. Each channel divides the clock by a selectable power of two. It counts down from a programmed start value and flags an expiry when the count would pass below zero. After an expiry the channel either reloads and keeps running, for periodic events, or stops itself, for single events. The status flag, gated by its own enable, drives a per-channel interrupt line.

Software uses a simple synchronous register port with 16-bit data. Each channel exposes four word registers: control, status, start value and live count. The count register gives a free-running timestamp when the start value is all ones and reload mode is chosen. The interrupt handler acknowledges an expiry by writing a one to bit 0 of the status register.

Top module: `dual_prescaled_timer`

## Requirements
- R1: Channel n (0 or 1) decodes byte offsets 0x80*n+0x80 (control), +0x84 (status), +0x88 (start value) and +0x8C (live count). A read of any other offset returns zero.
- R2: The control fields are bit 8 = interrupt enable, bit 5 = run enable, bit 4 = single-shot select (0 = reload) and bits [3:0] = divider code. Control reads return these fields, and all other bits read as zero.
- R3: With divider code c, the count moves once every 2^min(c,8) functional clocks. Codes 9 to 15 behave as code 8.
- R4: While running, the count drops by one per divided tick from the start value, over the full 16-bit range. While run enable is clear, the count holds its value.
- R5: The tick that finds the count at zero is the expiry, and it sets status bit 0. An expiry therefore comes (start+1) ticks after the start, for any start value, including 0 and 3.
- R6: In reload mode, an expiry copies the start value back into the count, and counting carries on.
- R7: In single-shot mode, an expiry clears run enable, and the count stays at zero.
- R8: A 0-to-1 write of run enable, or a write of the start value while running, loads the count from the start value and restarts the divider.
- R9: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged.
- R10: Each interrupt output equals its channel's status flag ANDed with its interrupt enable.
- R11: The channels are independent: activity on one never alters the other's count, flag or interrupt.
- R12: After reset, every register reads zero and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 10 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 2 | Per-channel interrupt, bit n for channel n |

## Verification
The channel assertions assume at most one register write per cycle and no change to the divider code in the cycle that follows a tick. Each property that predicts the next count leaves out cycles that hold a control or start-value write. The stimulus uses single-cycle writes only, and it reprograms a channel only after it has been disabled or has expired. The bench computes the count, flag and interrupt for every cycle from the number of divided ticks elapsed since the start, so every property is exercised only under these conditions.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int unsigned BIT_IE = 8;
    localparam int unsigned BIT_EN = 5;
    localparam int unsigned BIT_OS = 4;
    localparam int unsigned BIT_FLAG = 0;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_LOAD = 2'd2,
        REG_CNT  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              clr_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);
    localparam int PW = (MAX_CODE > 0) ? MAX_CODE : 1;

    typedef struct packed {
        logic [PW-1:0] pcnt;
    } pre_state_t;

    pre_state_t    st_d, st_q;
    logic [CODE_W-1:0] eff_code;
    logic [PW-1:0]     mask;

    always_comb begin
        eff_code = (code_i > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code_i;
        for (int i = 0; i < PW; i++) begin
            mask[i] = (i < int'(eff_code));
        end
        tick_o = run_i && ((st_q.pcnt & mask) == mask);
        st_d = st_q;
        if (clr_i) begin
            st_d.pcnt = '0;
        end else if (run_i) begin
            st_d.pcnt = st_q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: with a divider above one, two ticks never come back to back
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && (mask != '0)) |=> (!tick_o || (code_i != $past(code_i))));
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
    import ptmr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic              wr_stat_i,
    input  logic              wr_load_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] stat_o,
    output logic [DATA_W-1:0] load_o,
    output logic [DATA_W-1:0] cnt_o,
    output logic              irq_o
);
    typedef struct packed {
        logic              ie;
        logic              en;
        logic              os;
        logic [CODE_W-1:0] code;
        logic [DATA_W-1:0] load;
        logic [DATA_W-1:0] cnt;
        logic              flag;
    } ch_state_t;

    ch_state_t         st_d, st_q;
    logic              start;
    logic              tick;
    logic              expire;
    logic [DATA_W-1:0] start_val;

    ptmr_prescale #(
        .CODE_W   (CODE_W),
        .MAX_CODE (MAX_CODE)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.en),
        .clr_i  (start),
        .code_i (st_q.code),
        .tick_o (tick)
    );

    always_comb begin
        start     = (wr_ctrl_i && wdata_i[BIT_EN] && !st_q.en)
                 || (wr_load_i && st_q.en);
        start_val = wr_load_i ? wdata_i : st_q.load;
        expire    = tick && !start && (st_q.cnt == '0);

        st_d = st_q;
        if (wr_ctrl_i) begin
            st_d.ie   = wdata_i[BIT_IE];
            st_d.en   = wdata_i[BIT_EN];
            st_d.os   = wdata_i[BIT_OS];
            st_d.code = wdata_i[CODE_W-1:0];
        end
        if (wr_load_i) begin
            st_d.load = wdata_i;
        end
        if (start) begin
            st_d.cnt = start_val;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                if (st_q.os) begin
                    st_d.en = 1'b0;
                end else begin
                    st_d.cnt = st_q.load;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (wr_stat_i && wdata_i[BIT_FLAG]) begin
            st_d.flag = 1'b0;
        end
        if (expire) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl_o                 = '0;
        ctrl_o[BIT_IE]         = st_q.ie;
        ctrl_o[BIT_EN]         = st_q.en;
        ctrl_o[BIT_OS]         = st_q.os;
        ctrl_o[CODE_W-1:0]     = st_q.code;
        stat_o                 = '0;
        stat_o[BIT_FLAG]       = st_q.flag;
        load_o                 = st_q.load;
        cnt_o                  = st_q.cnt;
        irq_o                  = st_q.flag && st_q.ie;
    end

    // R4: a stopped channel keeps its count when nothing is written
    p_hold_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !wr_ctrl_i && !wr_load_i) |=> $stable(st_q.cnt));

    // R4: a tick above zero takes exactly one off the count
    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.cnt != '0 && !wr_ctrl_i && !wr_load_i)
        |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R5: a tick at zero leaves the flag raised
    p_flag_on_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.cnt == '0 && !wr_ctrl_i && !wr_load_i) |=> st_q.flag);

    // R6: reload mode restores the start value after an expiry
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.cnt == '0 && !st_q.os && !wr_ctrl_i && !wr_load_i)
        |=> (st_q.cnt == $past(st_q.load)));

    // R7: single-shot mode stops itself at expiry
    p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.cnt == '0 && st_q.os && !wr_ctrl_i && !wr_load_i)
        |=> (!st_q.en && st_q.cnt == '0));
endmodule

// File: rtl/dual_prescaled_timer.sv
module dual_prescaled_timer
    import ptmr_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 16,
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int STRIDE_LSB = 7;
    localparam int BLK_W      = ADDR_W - STRIDE_LSB;

    logic [BLK_W-1:0]  blk;
    logic              reg_ok;
    reg_sel_e          sel;
    logic [NUM_CH-1:0] hit;
    logic [DATA_W-1:0] ctrl_rd [NUM_CH];
    logic [DATA_W-1:0] stat_rd [NUM_CH];
    logic [DATA_W-1:0] load_rd [NUM_CH];
    logic [DATA_W-1:0] cnt_rd  [NUM_CH];

    always_comb begin
        blk    = bus_addr[ADDR_W-1:STRIDE_LSB];
        reg_ok = (bus_addr[STRIDE_LSB-1:4] == '0) && (bus_addr[1:0] == 2'b00);
        sel    = reg_sel_e'(bus_addr[3:2]);
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign hit[ch] = reg_ok && (blk == BLK_W'(ch + 1));

        ptmr_channel #(
            .DATA_W   (DATA_W),
            .CODE_W   (CODE_W),
            .MAX_CODE (MAX_CODE)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctrl_i (bus_wr && hit[ch] && sel == REG_CTRL),
            .wr_stat_i (bus_wr && hit[ch] && sel == REG_STAT),
            .wr_load_i (bus_wr && hit[ch] && sel == REG_LOAD),
            .wdata_i   (bus_wdata),
            .ctrl_o    (ctrl_rd[ch]),
            .stat_o    (stat_rd[ch]),
            .load_o    (load_rd[ch]),
            .cnt_o     (cnt_rd[ch]),
            .irq_o     (irq[ch])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (hit[ch]) begin
                case (sel)
                    REG_CTRL: bus_rdata = ctrl_rd[ch];
                    REG_STAT: bus_rdata = stat_rd[ch];
                    REG_LOAD: bus_rdata = load_rd[ch];
                    default:  bus_rdata = cnt_rd[ch];
                endcase
            end
        end
    end

    // R1: offsets outside every channel window read back as zero
    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |-> (bus_rdata == '0));
endmodule

// File: tb/dual_prescaled_timer_tb.sv
module dual_prescaled_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dual_prescaled_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic int a_ctrl(int ch); return ch * 128 + 128; endfunction
    function automatic int a_stat(int ch); return ch * 128 + 132; endfunction
    function automatic int a_load(int ch); return ch * 128 + 136; endfunction
    function automatic int a_cnt(int ch);  return ch * 128 + 140; endfunction

    function automatic int exp_count(int ld, int t, int os);
        if (t <= ld) return ld - t;
        if (os != 0) return 0;
        return ld - (t % (ld + 1));
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_addr  = 10'(a);
        bus_wdata = 16'(d);
        bus_wr    = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output int d);
        bus_addr = 10'(a);
        #1 d = int'(bus_rdata);
    endtask

    task automatic follow(int ch, int ld, int eff, int os, int ie, int n);
        int v;
        for (int j = 1; j <= n; j++) begin
            int t, ec, ef;
            @(posedge clk);
            @(negedge clk);
            t  = j >> eff;
            ec = exp_count(ld, t, os);
            ef = (t > ld) ? 1 : 0;
            rd(a_cnt(ch), v);
            if (t <= ld)      chk("R3/R4 count", v, ec);
            else if (os == 0) chk("R6 reload count", v, ec);
            else              chk("R7 single-shot hold", v, ec);
            rd(a_stat(ch), v);
            chk("R5 expiry flag", v, ef);
            chk("R10 irq", int'(irq[ch]), ef & ie);
        end
    endtask

    task automatic run_case(int ch, int ld, int code, int os, int ie);
        int eff, per, n, oc, v, cv;
        eff = (code > 8) ? 8 : code;
        per = (ld + 1) << eff;
        n   = (os != 0) ? per + 4 : 2 * per + 3;
        wr(a_ctrl(ch), 0);
        wr(a_stat(ch), 1);
        wr(a_load(ch), ld);
        @(negedge clk);
        rd(a_cnt(1 - ch), oc);
        cv = (ie << 8) | 32 | (os << 4) | code;
        wr(a_ctrl(ch), cv);
        follow(ch, ld, eff, os, ie, n);
        rd(a_ctrl(ch), v);
        chk("R7/R2 control after run", v, (os != 0) ? (cv & ~32) : cv);
        rd(a_cnt(1 - ch), v);
        chk("R11 other count untouched", v, oc);
        chk("R11 other irq low", int'(irq[1 - ch]), 0);
        wr(a_ctrl(ch), 0);
        wr(a_stat(ch), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int lds [3] = '{0, 3, 5};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        for (int ch = 0; ch < 2; ch++) begin
            rd(a_ctrl(ch), v); chk("R12 reset control", v, 0);
            rd(a_stat(ch), v); chk("R12 reset status", v, 0);
            rd(a_load(ch), v); chk("R12 reset start", v, 0);
            rd(a_cnt(ch), v);  chk("R12 reset count", v, 0);
        end
        chk("R12 reset irq", int'(irq), 0);

        // R1: unmapped offsets
        begin
            int bad [6] = '{'h000, 'h004, 'h090, 'h180, 'h3FC, 'h081};
            wr(a_load(0), 'h1234);
            wr(a_load(1), 'h4321);
            @(negedge clk);
            foreach (bad[i]) begin
                rd(bad[i], v);
                chk("R1 unmapped read", v, 0);
            end
            rd(a_load(0), v); chk("R1 channel 0 start offset", v, 'h1234);
            rd(a_load(1), v); chk("R1 channel 1 start offset", v, 'h4321);
        end

        // R2: control field readback
        wr(a_ctrl(1), 'hFFDF);
        @(negedge clk);
        rd(a_ctrl(1), v); chk("R2 control mask", v, 'h011F);
        wr(a_ctrl(1), 0);

        // R3..R7, R10, R11: sweep of dividers, start values and modes
        for (int code = 0; code < 10; code++)
            foreach (lds[i])
                for (int os = 0; os < 2; os++)
                    run_case(0, lds[i], code, os, os ^ (lds[i] & 1));
        for (int code = 0; code < 5; code += 2)
            for (int os = 0; os < 2; os++) begin
                run_case(1, 3, code, os, 1);
                run_case(1, 7, code, os, os);
            end

        // R4: full-range start and hold while stopped
        wr(a_load(0), 'hFFFF);
        wr(a_ctrl(0), 32);
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rd(a_cnt(0), v); chk("R4 full-range count", v, 'hFFFD);
        wr(a_ctrl(0), 0);
        wr(a_load(0), 100);
        wr(a_ctrl(0), 32);
        repeat (5) @(posedge clk);
        wr(a_ctrl(0), 0);
        @(negedge clk);
        rd(a_cnt(0), v); chk("R4 count when stopped", v, 94);
        repeat (6) @(posedge clk);
        @(negedge clk);
        rd(a_cnt(0), v); chk("R4 hold while stopped", v, 94);

        // R8: start-value write while running restarts count and divider
        wr(a_stat(1), 1);
        wr(a_load(1), 10);
        wr(a_ctrl(1), 256 | 32 | 1);
        repeat (7) @(posedge clk);
        wr(a_load(1), 4);
        follow(1, 4, 1, 0, 1, 14);
        @(negedge clk);
        rd(a_load(1), v); chk("R8 new start value", v, 4);
        wr(a_ctrl(1), 0);

        // R9: status clear semantics
        wr(a_stat(1), 1);
        wr(a_load(1), 0);
        wr(a_ctrl(1), 256 | 32 | 16);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(a_stat(1), v); chk("R9 flag raised", v, 1);
        wr(a_stat(1), 0);
        @(negedge clk);
        rd(a_stat(1), v); chk("R9 write zero keeps flag", v, 1);
        chk("R9 irq kept", int'(irq[1]), 1);
        wr(a_stat(1), 1);
        @(negedge clk);
        rd(a_stat(1), v); chk("R9 write one clears flag", v, 0);
        chk("R9 irq cleared", int'(irq[1]), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule